// File: doc/BRIEF.md
# Low-Voltage Monitor Status Register

This block is the digital side of a supply-voltage monitor. An analog sense stage provides two comparator pairs, one for each tolerance setting. Each pair has a "supply below trip point" output and a "supply above recovery point" output. The block passes all four comparator outputs through a two-flop synchronizer. It then filters the selected pair in time and keeps a debounced low-voltage flag. The flag sets only after the supply has stayed below the trip point for a fixed count of clocks. It clears once the supply rises above the recovery point. While the supply sits between the two levels, the flag keeps its last value.

A single byte register holds the flag as a read-only bit and holds a tolerance-select bit, which the analog stage uses to pick its comparator pair. Two configuration bits are inputs to the block: a reset-enable bit and a power-enable bit. When both are clear, a write that changes the tolerance while the supply is already below the newly chosen trip point raises a one-cycle reset request toward the chip reset controller. In wait mode the monitor runs only if the power-enable bit is set. The block raises no interrupt.

Top module: `lvmon_status`

## Requirements
- R1: After synchronous reset, `reg_rdata` reads 0x00, and `tol_sel`, `low_flag` and `lv_rst_req` are 0.
- R2: `reg_rdata` bit 7 carries the low-voltage flag and bit 5 carries the tolerance select. Every other bit reads 0.
- R3: A write takes effect only when `reg_en` and `reg_we` are both 1. Only bit 5 of `reg_wdata` is stored; bit 7 and the reserved bits are ignored. The new value is visible after the write clock edge.
- R4: `tol_sel` = 1 picks comparator pair index 1 (5 percent). `tol_sel` = 0 picks index 0 (10 percent). The unselected pair does not affect the flag.
- R5: If the selected below-trip input stays at 1, the flag is still 0 after 37 clock edges and is 1 after 38 edges (THRESH = 36 filtered samples plus 2 synchronizer stages).
- R6: A low period shorter than THRESH synchronized samples leaves the flag clear. Any single sample with the below-trip input at 0 restarts the count.
- R7: When the selected above-recovery input is 1 and the monitor is running, the flag reads 0 by the third clock edge after the input rises. This input takes priority over below-trip.
- R8: While both selected comparator inputs are 0, the flag holds its previous value.
- R9: A write that changes the tolerance select, made while `cfg_rst_en` and `cfg_pwr_en` are both 0 and while the synchronized below-trip input of the newly selected pair is 1, drives `lv_rst_req` to 1 for exactly the one cycle after the write edge.
- R10: No reset request is raised if either configuration bit is 1, if the new pair is not below trip, or if the write leaves the select unchanged.
- R11: While `wait_mode` = 1 and `cfg_pwr_en` = 0, the filter count is held at zero and the flag keeps its value. With `cfg_pwr_en` = 1, monitoring continues in wait mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Monitor clock |
| rst | input | 1 | Synchronous active-high reset |
| cmp_below | input | 2 | Below-trip comparator outputs; index 1 = 5 %, index 0 = 10 % |
| cmp_above | input | 2 | Above-recovery comparator outputs; same indexing |
| cfg_rst_en | input | 1 | Configuration: reset-enable bit |
| cfg_pwr_en | input | 1 | Configuration: power-enable bit |
| wait_mode | input | 1 | Chip is in wait mode |
| reg_en | input | 1 | Register selected |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Register read value |
| tol_sel | output | 1 | Selected tolerance to the analog stage |
| low_flag | output | 1 | Debounced low-voltage flag |
| lv_rst_req | output | 1 | One-cycle low-voltage reset request |

## Verification
The bench targets the exact edge on which the flag rises. A filter that is off by one would set the flag a cycle early or a cycle late, or would let a 35-sample dip through. It checks that a single high sample in the middle of a long low period restarts the count; a counter that only saturated without clearing would falsely flag two short dips. It checks that the tolerance-change request fires only when both configuration bits are clear and the new pair is low, so a design that used the old pair's comparator or ignored a configuration bit would pulse at the wrong time. Finally, it checks that wait mode without power-enable freezes a set flag even while the supply is above recovery.

// File: rtl/lvmon_pkg.sv
package lvmon_pkg;
  localparam int REG_W     = 8;
  localparam int FLAG_POS  = 7;
  localparam int TOL_POS   = 5;
  localparam int NUM_PAIRS = 2;
  localparam int PAIR_IDX_W = $clog2(NUM_PAIRS);
endpackage

// File: rtl/lvmon_sync.sv
module lvmon_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stg[s] <= '0;
        else     stg[s] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stg[s] <= '0;
        else     stg[s] <= stg[s-1];
      end
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/lvmon_filter.sv
module lvmon_filter #(
  parameter int THRESH = 36
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic below,
  input  logic above,
  output logic flag
);
  localparam int CNT_W = $clog2(THRESH + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(THRESH);
  localparam logic [CNT_W-1:0] CNT_PRE = CNT_W'(THRESH - 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      flag <= 1'b0;
    end else if (!run) begin
      cnt  <= '0;
    end else if (above) begin
      cnt  <= '0;
      flag <= 1'b0;
    end else if (below) begin
      if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
      if (cnt >= CNT_PRE) flag <= 1'b1;
    end else begin
      cnt  <= '0;
    end
  end

  // R7: above-recovery while running forces the flag low next cycle
  a_r7_above_clears: assert property (@(posedge clk) disable iff (rst)
    (run && above) |=> !flag);

  // R8: between levels the flag is held
  a_r8_between_holds: assert property (@(posedge clk) disable iff (rst)
    (run && !above && !below) |=> $stable(flag));

  // R5: a rising flag must come from a below-trip sample
  a_r5_rise_needs_low: assert property (@(posedge clk) disable iff (rst)
    $rose(flag) |-> $past(below && run));

  // R11: frozen monitor keeps the flag
  a_r11_frozen_holds: assert property (@(posedge clk) disable iff (rst)
    !run |=> $stable(flag));
endmodule

// File: rtl/lvmon_status.sv
module lvmon_status
  import lvmon_pkg::*;
#(
  parameter int THRESH      = 36,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_PAIRS-1:0] cmp_below,
  input  logic [NUM_PAIRS-1:0] cmp_above,
  input  logic                 cfg_rst_en,
  input  logic                 cfg_pwr_en,
  input  logic                 wait_mode,
  input  logic                 reg_en,
  input  logic                 reg_we,
  input  logic [REG_W-1:0]     reg_wdata,
  output logic [REG_W-1:0]     reg_rdata,
  output logic                 tol_sel,
  output logic                 low_flag,
  output logic                 lv_rst_req
);
  localparam int SYNC_W = 2 * NUM_PAIRS;

  logic [SYNC_W-1:0]    sync_q;
  logic [NUM_PAIRS-1:0] below_s;
  logic [NUM_PAIRS-1:0] above_s;
  logic                 tol_q;
  logic                 req_q;
  logic                 flag_w;
  logic                 wr_hit;
  logic                 new_tol;
  logic                 tol_chg;
  logic                 run;

  lvmon_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({cmp_above, cmp_below}),
    .q   (sync_q)
  );

  assign below_s = sync_q[NUM_PAIRS-1:0];
  assign above_s = sync_q[SYNC_W-1:NUM_PAIRS];

  assign run     = !wait_mode || cfg_pwr_en;
  assign wr_hit  = reg_en && reg_we;
  assign new_tol = reg_wdata[TOL_POS];
  assign tol_chg = wr_hit && (new_tol != tol_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      tol_q <= 1'b0;
      req_q <= 1'b0;
    end else begin
      if (wr_hit) tol_q <= new_tol;
      req_q <= tol_chg && !cfg_rst_en && !cfg_pwr_en
               && below_s[PAIR_IDX_W'(new_tol)];
    end
  end

  lvmon_filter #(.THRESH(THRESH)) u_filter (
    .clk   (clk),
    .rst   (rst),
    .run   (run),
    .below (below_s[PAIR_IDX_W'(tol_q)]),
    .above (above_s[PAIR_IDX_W'(tol_q)]),
    .flag  (flag_w)
  );

  always_comb begin
    reg_rdata           = '0;
    reg_rdata[FLAG_POS] = flag_w;
    reg_rdata[TOL_POS]  = tol_q;
  end

  assign tol_sel    = tol_q;
  assign low_flag   = flag_w;
  assign lv_rst_req = req_q;

  // R3: select changes only through a write
  a_r3_tol_hold: assert property (@(posedge clk) disable iff (rst)
    !(reg_en && reg_we) |=> $stable(tol_sel));

  // R9: a request always follows a write cycle
  a_r9_req_from_write: assert property (@(posedge clk) disable iff (rst)
    lv_rst_req |-> $past(reg_en && reg_we));

  // R10: either configuration bit blocks the request
  a_r10_cfg_blocks: assert property (@(posedge clk) disable iff (rst)
    (cfg_rst_en || cfg_pwr_en) |=> !lv_rst_req);
endmodule

// File: tb/lvmon_status_test.sv
module lvmon_status_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] cmp_below = '0;
  logic [1:0] cmp_above = '0;
  logic       cfg_rst_en = 1'b0;
  logic       cfg_pwr_en = 1'b0;
  logic       wait_mode = 1'b0;
  logic       reg_en = 1'b0;
  logic       reg_we = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       tol_sel;
  logic       low_flag;
  logic       lv_rst_req;

  always #4 clk = ~clk;

  lvmon_status uut (
    .clk(clk), .rst(rst), .cmp_below(cmp_below), .cmp_above(cmp_above),
    .cfg_rst_en(cfg_rst_en), .cfg_pwr_en(cfg_pwr_en), .wait_mode(wait_mode),
    .reg_en(reg_en), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .tol_sel(tol_sel), .low_flag(low_flag),
    .lv_rst_req(lv_rst_req)
  );

  typedef struct {
    logic [7:0] rd;
    logic       rq;
    string      tag;
  } exp_t;

  exp_t sbq[$];
  exp_t cur;
  int   n_chk = 0;
  int   n_bad = 0;
  bit   done = 1'b0;

  always @(negedge clk) begin
    while (sbq.size() != 0) begin
      cur = sbq.pop_front();
      n_chk++;
      if (reg_rdata !== cur.rd || tol_sel !== cur.rd[5] ||
          low_flag !== cur.rd[7] || lv_rst_req !== cur.rq) begin
        n_bad++;
        $display("FAIL %s: rdata=%h tol=%b flag=%b req=%b expected rdata=%h req=%b",
                 cur.tag, reg_rdata, tol_sel, low_flag, lv_rst_req, cur.rd, cur.rq);
      end
    end
  end

  task automatic tick(int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic expect_state(logic [7:0] rd, logic rq, string tag);
    exp_t e;
    e.rd = rd; e.rq = rq; e.tag = tag;
    sbq.push_back(e);
  endtask

  task automatic wr(logic [7:0] d, logic [7:0] exp_rd, logic exp_rq, string tag);
    @(negedge clk);
    reg_en = 1'b1; reg_we = 1'b1; reg_wdata = d;
    @(posedge clk);
    expect_state(exp_rd, exp_rq, tag);
    @(negedge clk);
    reg_en = 1'b0; reg_we = 1'b0;
  endtask

  initial begin
    tick(3);
    @(negedge clk); rst = 1'b0;
    tick(1); expect_state(8'h00, 1'b0, "R1 reset state");

    wr(8'hFF, 8'h20, 1'b0, "R3 only bit5 stored");
    @(negedge clk); reg_en = 1'b0; reg_we = 1'b1; reg_wdata = 8'h00;
    tick(1); expect_state(8'h20, 1'b0, "R3 write without enable ignored");
    @(negedge clk); reg_we = 1'b0;
    wr(8'hDF, 8'h00, 1'b0, "R2 select clears");
    wr(8'h20, 8'h20, 1'b0, "R2 select sets");

    @(negedge clk); cmp_below = 2'b01;
    tick(50); expect_state(8'h20, 1'b0, "R4 unselected pair ignored");
    @(negedge clk); cmp_below = 2'b00;
    tick(3);

    @(negedge clk); cmp_below = 2'b10;
    tick(37); expect_state(8'h20, 1'b0, "R5 not yet set");
    tick(1);  expect_state(8'hA0, 1'b0, "R5 flag set");

    @(negedge clk); cmp_below = 2'b00;
    tick(10); expect_state(8'hA0, 1'b0, "R8 hold set");

    @(negedge clk); cmp_above = 2'b10;
    tick(2); expect_state(8'hA0, 1'b0, "R7 before clear");
    tick(1); expect_state(8'h20, 1'b0, "R7 cleared");
    @(negedge clk); cmp_above = 2'b00;
    tick(5); expect_state(8'h20, 1'b0, "R8 hold clear");

    @(negedge clk); cmp_below = 2'b10;
    tick(35);
    @(negedge clk); cmp_below = 2'b00;
    tick(10); expect_state(8'h20, 1'b0, "R6 short dip");

    @(negedge clk); cmp_below = 2'b10;
    tick(30);
    @(negedge clk); cmp_below = 2'b00;
    tick(1);
    @(negedge clk); cmp_below = 2'b10;
    tick(30);
    @(negedge clk); cmp_below = 2'b00;
    tick(10); expect_state(8'h20, 1'b0, "R6 count restarts");

    @(negedge clk); cmp_below = 2'b01;
    tick(3);
    wr(8'h00, 8'h00, 1'b1, "R9 request pulse");
    tick(1); expect_state(8'h00, 1'b0, "R9 pulse one cycle");
    @(negedge clk); cmp_below = 2'b00;
    tick(3);

    @(negedge clk); cfg_rst_en = 1'b1; cmp_below = 2'b10;
    tick(3);
    wr(8'h20, 8'h20, 1'b0, "R10 reset-enable blocks");
    @(negedge clk); cfg_rst_en = 1'b0; cmp_below = 2'b00;
    tick(3);

    @(negedge clk); cfg_pwr_en = 1'b1; cmp_below = 2'b01;
    tick(3);
    wr(8'h00, 8'h00, 1'b0, "R10 power-enable blocks");
    @(negedge clk); cfg_pwr_en = 1'b0;
    wr(8'h00, 8'h00, 1'b0, "R10 unchanged select");
    @(negedge clk); cmp_below = 2'b00;
    tick(3); expect_state(8'h00, 1'b0, "R10 flag untouched");

    @(negedge clk); wait_mode = 1'b1; cmp_below = 2'b01;
    tick(60); expect_state(8'h00, 1'b0, "R11 frozen in wait");
    @(negedge clk); cfg_pwr_en = 1'b1;
    tick(40); expect_state(8'h80, 1'b0, "R11 active with power-enable");
    @(negedge clk); cfg_pwr_en = 1'b0; cmp_below = 2'b00; cmp_above = 2'b01;
    tick(10); expect_state(8'h80, 1'b0, "R11 frozen flag held");
    @(negedge clk); wait_mode = 1'b0;
    tick(3); expect_state(8'h00, 1'b0, "R7 clears after wake");
    @(negedge clk); cmp_above = 2'b00;

    @(negedge clk);
    #1;
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule